// File: doc/BRIEF.md
# Audio Port Event Interrupt Controller

This block gathers the event strobes that one direction (transmit or receive) of a multichannel audio serial port raises. These events are buffer underrun or overrun, an unexpected frame sync, a clock failure, a data-port error, the last slot of a frame, data ready and start of frame. Each single-cycle strobe sets a sticky flag. An enable register selects which flags may raise the block's single active-high interrupt line. Software clears a flag by writing 1 to it.

The status word carries the seven flags. It also carries two derived bits: an error summary that stays set while any of the four error flags is set, and the live parity of the current time-division slot. A read-only vector lets software see which serializer is ready and so find which one caused a data event. The same module, with no change, serves the transmit side or the receive side.

Top module: `audio_evt_irq`

## Requirements
- R1: After reset all seven flags and all enables are 0, the status word reads 0 apart from bit 3 (slot parity), and irq_o is low.
- R2: A strobe on evt_strobe[i] sets its flag at the next rising clock edge. The status bit is given by the strobe index: index 0 (underrun/overrun) sets bit 0, 1 (sync error) sets bit 1, 2 (clock fail) sets bit 2, 3 (data-port error) sets bit 7, 4 (last slot) sets bit 4, 5 (data ready) sets bit 5, and 6 (start of frame) sets bit 6.
- R3: A set flag stays set until software writes 1 to its status bit at register address 1. Writing 0 to that bit leaves the flag unchanged.
- R4: When a strobe and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R5: Status bit 8 is 1 whenever any of the flags for indices 0, 1, 2 or 3 is set. It returns to 0 only after all four of those flags are cleared.
- R6: Status bit 3 follows the slot_odd input directly. Writes to status bits 3 and 8 have no effect.
- R7: The enable register is at address 0. Enable bits 0, 1, 2, 3, 4, 5 and 7 belong to strobe indices 0, 1, 2, 3, 4, 5 and 6 in that order. Bit 6 and all bits above 7 read as 0 and cannot be set.
- R8: irq_o is registered. It equals the OR of every flag ANDed with its enable, one clock after those values change.
- R9: ready_o and register address 2 show ser_ready. Writes to address 2 are ignored, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_strobe | input | 7 | Single-cycle event strobes, by index (see R2) |
| slot_odd | input | 1 | 1 when the current slot is odd |
| ser_ready | input | NUM_SER | Per-serializer ready flags |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 enable, 1 status, 2 ready) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| status_o | output | 9 | Status word |
| ready_o | output | NUM_SER | Serializer ready vector |
| irq_o | output | 1 | Active-high interrupt |

## Verification
A table drives each strobe on its own, then several mixed groups, and finally all seven strobes together, with every enable set. Single strobes expose any mix-up in the index-to-bit mapping. The mixed groups test whether the error summary tracks only the four error flags. Directed cases then separate four things: a clearing write from a write of zero, a set from a clear in the same cycle, the two derived bits from the writable bits, and the one-cycle interrupt delay after a flag is set from the delay after an enable is written.

// File: rtl/audio_evt_irq_pkg.sv
package audio_evt_irq_pkg;
  localparam int NUM_EVT = 7;
  localparam int STAT_W  = 9;
  localparam int EN_W    = 8;
  localparam int NUM_ERR = 4;
  localparam int BIT_SLOT = 3;
  localparam int BIT_ESUM = 8;

  typedef enum logic [1:0] {
    RA_ENABLE = 2'd0,
    RA_STATUS = 2'd1,
    RA_READY  = 2'd2,
    RA_NONE   = 2'd3
  } reg_addr_e;

  // status bit position of an event index
  function automatic int stat_pos(input int idx);
    case (idx)
      3:       stat_pos = 7;
      default: stat_pos = idx;
    endcase
  endfunction

  // enable bit position of an event index
  function automatic int en_pos(input int idx);
    case (idx)
      6:       en_pos = 7;
      default: en_pos = idx;
    endcase
  endfunction

  function automatic logic err_summary(input logic [NUM_EVT-1:0] fl);
    err_summary = |fl[NUM_ERR-1:0];
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input logic [NUM_EVT-1:0] fl,
                                                     input logic slot);
    logic [STAT_W-1:0] s;
    s = '0;
    for (int i = 0; i < NUM_EVT; i++) s[stat_pos(i)] = fl[i];
    s[BIT_SLOT] = slot;
    s[BIT_ESUM] = err_summary(fl);
    return s;
  endfunction

  function automatic logic [NUM_EVT-1:0] unpack_status(input logic [STAT_W-1:0] w);
    logic [NUM_EVT-1:0] f;
    for (int i = 0; i < NUM_EVT; i++) f[i] = w[stat_pos(i)];
    return f;
  endfunction

  function automatic logic [EN_W-1:0] pack_en(input logic [NUM_EVT-1:0] en);
    logic [EN_W-1:0] w;
    w = '0;
    for (int i = 0; i < NUM_EVT; i++) w[en_pos(i)] = en[i];
    return w;
  endfunction

  function automatic logic [NUM_EVT-1:0] unpack_en(input logic [EN_W-1:0] w);
    logic [NUM_EVT-1:0] en;
    for (int i = 0; i < NUM_EVT; i++) en[i] = w[en_pos(i)];
    return en;
  endfunction
endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[g] <= 1'b0;
      else if (set_i[g])   flag_q[g] <= 1'b1;   // set beats clear
      else if (clr_i[g])   flag_q[g] <= 1'b0;
    end

    a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_q[g]);
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !clr_i[g]) |=> flag_q[g]);
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !flag_q[g]);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[g] && !set_i[g]) |=> !flag_q[g]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/evt_reg_port.sv
module evt_reg_port
  import audio_evt_irq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 2,
  parameter int NUM_SER = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [STAT_W-1:0]  status,
  input  logic [NUM_SER-1:0] ready,
  output logic [NUM_EVT-1:0] en_o,
  output logic [NUM_EVT-1:0] clr_o,
  output logic [DATA_W-1:0]  rdata
);
  logic [NUM_EVT-1:0] en_q;
  logic               wr_en_reg;
  logic               wr_stat_reg;

  assign wr_en_reg   = we && (addr == ADDR_W'(RA_ENABLE));
  assign wr_stat_reg = we && (addr == ADDR_W'(RA_STATUS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_q <= '0;
    else if (wr_en_reg) en_q <= unpack_en(wdata[EN_W-1:0]);
  end

  // derived bits 3 and 8 have no flag behind them, so writes there drop out
  assign clr_o = wr_stat_reg ? unpack_status(wdata[STAT_W-1:0]) : '0;
  assign en_o  = en_q;

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(RA_ENABLE): rdata = DATA_W'(pack_en(en_q));
      ADDR_W'(RA_STATUS): rdata = DATA_W'(status);
      ADDR_W'(RA_READY):  rdata = DATA_W'(ready);
      default:            rdata = '0;
    endcase
  end

  a_r7_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_reg |=> en_q == unpack_en($past(wdata[EN_W-1:0])));
  a_r7_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_reg |=> $stable(en_q));
endmodule

// File: rtl/evt_irq_gen.sv
module evt_irq_gen #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic hit;
  logic irq_q;

  assign hit = |(flag_i & en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= hit;
  end

  assign irq_o = irq_q;

  a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> irq_q);
  a_r8_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !irq_q);
endmodule

// File: rtl/audio_evt_irq.sv
module audio_evt_irq
  import audio_evt_irq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 2,
  parameter int NUM_SER = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_strobe,
  input  logic               slot_odd,
  input  logic [NUM_SER-1:0] ser_ready,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [STAT_W-1:0]  status_o,
  output logic [NUM_SER-1:0] ready_o,
  output logic               irq_o
);
  logic [NUM_EVT-1:0] flags;
  logic [NUM_EVT-1:0] enables;
  logic [NUM_EVT-1:0] clears;
  logic               stat_wr;

  evt_flag_bank #(.N(NUM_EVT)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(evt_strobe), .clr_i(clears), .flag_o(flags)
  );

  evt_reg_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SER(NUM_SER)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .status(status_o), .ready(ser_ready), .en_o(enables), .clr_o(clears),
    .rdata(reg_rdata)
  );

  evt_irq_gen #(.N(NUM_EVT)) u_irq (
    .clk(clk), .rst_n(rst_n), .flag_i(flags), .en_i(enables), .irq_o(irq_o)
  );

  assign status_o = pack_status(flags, slot_odd);
  assign ready_o  = ser_ready;
  assign stat_wr  = reg_we && (reg_addr == ADDR_W'(RA_STATUS));

  // R5: the summary cannot drop without a status write
  a_r5_summary_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[BIT_ESUM] && !stat_wr) |=> status_o[BIT_ESUM]);
  a_r5_summary_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_strobe[NUM_ERR-1:0]) |=> status_o[BIT_ESUM]);
endmodule

// File: tb/audio_evt_irq_bench.sv
module audio_evt_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt_strobe = '0;
  logic        slot_odd = 1'b0;
  logic [3:0]  ser_ready = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [8:0]  status_o;
  logic [3:0]  ready_o;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  audio_evt_irq u_audio_evt_irq (
    .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .slot_odd(slot_odd),
    .ser_ready(ser_ready), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .status_o(status_o),
    .ready_o(ready_o), .irq_o(irq_o)
  );

  // {strobe[6:0], expected status[8:0]} with slot_odd = 0
  localparam logic [15:0] VEC [10] = '{
    {7'h01, 9'h101}, {7'h02, 9'h102}, {7'h04, 9'h104}, {7'h08, 9'h180},
    {7'h10, 9'h010}, {7'h20, 9'h020}, {7'h40, 9'h040}, {7'h48, 9'h1C0},
    {7'h30, 9'h030}, {7'h7F, 9'h1F7}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [6:0] m);
    evt_strobe = m;
    tick();
    evt_strobe = '0;
  endtask

  task automatic clear_all();
    wr(2'd1, 16'h01FF);
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    tick(); tick();
    // R1 reset state
    chk("R1 status", status_o, 9'h000);
    chk("R1 irq", irq_o, 1'b0);
    rst_n = 1'b1;
    tick();
    rd(2'd0, d); chk("R1 enables", d, 16'h0000);

    // R2/R5/R8 vector table
    wr(2'd0, 16'h00BF);
    for (int i = 0; i < 10; i++) begin
      clear_all();
      pulse(VEC[i][15:9]);
      chk("R2 status", status_o, VEC[i][8:0]);
      chk("R8 irq not yet", irq_o, 1'b0);
      tick();
      chk("R8 irq after one clock", irq_o, 1'b1);
      rd(2'd1, d); chk("R2 status readback", d, {7'd0, VEC[i][8:0]});
    end

    // R3 write zero then write one
    clear_all();
    pulse(7'h10);
    wr(2'd1, 16'h0000);
    chk("R3 write zero keeps", status_o, 9'h010);
    wr(2'd1, 16'h0010);
    chk("R3 write one clears", status_o, 9'h000);

    // R4 set and clear collide
    evt_strobe = 7'h20; reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0020;
    tick();
    evt_strobe = '0; reg_we = 1'b0;
    chk("R4 set wins", status_o, 9'h020);

    // R5 summary across partial clears
    clear_all();
    pulse(7'h09);
    chk("R5 two errors", status_o, 9'h181);
    wr(2'd1, 16'h0001);
    chk("R5 one left", status_o, 9'h180);
    wr(2'd1, 16'h0080);
    chk("R5 all cleared", status_o, 9'h000);

    // R6 slot parity live, derived bits not writable
    slot_odd = 1'b1;
    #1 chk("R6 slot odd", status_o, 9'h008);
    tick();
    pulse(7'h02);
    wr(2'd1, 16'h0108);
    chk("R6 derived write ignored", status_o, 9'h10A);
    slot_odd = 1'b0;
    #1 chk("R6 slot even", status_o, 9'h102);

    // R7 enable layout
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d); chk("R7 enable readback", d, 16'h00BF);
    clear_all();
    wr(2'd0, 16'h0040);
    rd(2'd0, d); chk("R7 bit6 reserved", d, 16'h0000);
    pulse(7'h40); tick();
    chk("R7 masked sof no irq", irq_o, 1'b0);
    wr(2'd0, 16'h0080);
    chk("R8 enable delay", irq_o, 1'b0);
    tick();
    chk("R7 enable bit7 drives sof", irq_o, 1'b1);
    wr(2'd1, 16'h0040);
    tick();
    chk("R8 irq drops after clear", irq_o, 1'b0);

    // R9 ready vector
    ser_ready = 4'hA;
    #1 chk("R9 ready port", ready_o, 4'hA);
    rd(2'd2, d); chk("R9 ready reg", d, 16'h000A);
    tick();
    wr(2'd2, 16'hFFFF);
    rd(2'd2, d); chk("R9 ready write ignored", d, 16'h000A);
    rd(2'd3, d); chk("R9 address 3 zero", d, 16'h0000);

    // R1 reset mid-run
    pulse(7'h7F);
    tick();
    rst_n = 1'b0;
    #1 chk("R1 reset flags", status_o, 9'h000);
    chk("R1 reset irq", irq_o, 1'b0);
    rd(2'd0, d); chk("R1 reset enables", d, 16'h0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule